// File: doc/BRIEF.md
# FIFO Ready-Pin Generator

This block sits between a host bus and a UART serializer and holds one 64-byte transmit queue and one 64-byte receive queue. The host writes bytes into the transmit queue and reads bytes out of the receive queue. On the other side, the serializer pops transmit bytes and pushes received ones. Both fill counts are visible as outputs.

Two active-low readiness outputs tell the host when to move data. Their meaning depends on two control inputs: a queue-enable bit and a block-transfer bit. There are three pin modes.

- **Queue disabled:** each side behaves as a single holding byte.
- **Single-character:** the queues are enabled and block transfer is off.
- **Block-transfer:** the queues are enabled and block transfer is on. In this mode the receive pin latches low once the fill count reaches a programmable trigger level, or when a time-out strobe arrives while data is waiting. It stays low until the receive queue drains completely. The transmit pin stays low as long as any slot is free.

Both readiness outputs are registered.

Top module: `fifo_ready_gen`

## Requirements
- R1: During and after a synchronous active-high `rst` the queues are empty, `tx_ovf` is 0, `rxrdy_n` is 1 and `txrdy_n` is 0.
- R2: Each queue holds up to 64 bytes when `fifo_en`=1 and exactly one byte when `fifo_en`=0. Bytes leave in the order they arrived. `tx_level` and `rx_level` report the current fill counts.
- R3: When `fifo_en`=0 or `blk_mode`=0, `rxrdy_n` is 0 exactly when `rx_level` is nonzero, and `txrdy_n` is 0 exactly when `tx_level` is zero. With `fifo_en`=0, `blk_mode` has no effect.
- R4: When `fifo_en`=1 and `blk_mode`=1, `rxrdy_n` falls when `rx_level` reaches the effective trigger, or when `rx_timeout` pulses while `rx_level` is nonzero. It then stays 0 until `rx_level` becomes 0. A time-out while the receive queue is empty has no effect.
- R5: When `fifo_en`=1 and `blk_mode`=1, `txrdy_n` is 1 only when `tx_level` equals 64.
- R6: The effective trigger is `rx_trig` clamped to the range 1 to 64. A value of 0 acts as 1, and any value above 64 acts as 64.
- R7: A host write to a full transmit queue is dropped and sets the sticky `tx_ovf`, which only `rst` clears. If `ser_tx_pop` removes a byte in the same cycle, the write is accepted instead. A serializer push into a full receive queue is dropped.
- R8: A host read of an empty receive queue returns `host_rdata`=0x00 and leaves `rx_level` at 0. A serializer pop of an empty transmit queue leaves `tx_level` at 0.
- R9: An accepted push and pop on the same queue in one cycle leave its count unchanged. Each readiness pin reflects the count one clock after the count changes.
- R10: Any change of pin mode clears the block-mode receive latch. The pins are then re-evaluated from the current fill levels, so a level below the trigger gives `rxrdy_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue enable (0: single holding byte per side) |
| blk_mode | input | 1 | Block-transfer pin mode, effective only with fifo_en=1 |
| rx_trig | input | 7 | Receive trigger level |
| rx_timeout | input | 1 | Receive time-out strobe, one cycle |
| host_wr | input | 1 | Host write strobe into transmit queue |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from receive queue |
| host_rdata | output | 8 | Receive queue head byte, 0x00 when empty |
| ser_tx_pop | input | 1 | Serializer takes one transmit byte |
| ser_tx_data | output | 8 | Transmit queue head byte |
| ser_rx_push | input | 1 | Serializer delivers one received byte |
| ser_rx_data | input | 8 | Received byte |
| tx_level | output | 7 | Transmit fill count |
| rx_level | output | 7 | Receive fill count |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| txrdy_n | output | 1 | Transmit ready, active low |
| rxrdy_n | output | 1 | Receive ready, active low |

## Verification
Two functions can fall in the same cycle: a push and a pop on one queue. The most telling case is a host write landing on a full transmit queue while the serializer pops it. The bench fills the transmit queue to 64 and then raises `host_wr` and `ser_tx_pop` in one cycle. It expects the count to stay at 64 and `tx_ovf` to stay clear, and a lone write afterwards must set the flag. The same pairing is provoked on the receive queue at a mid-level count, and there the count must not move.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;

  typedef enum logic [1:0] {
    PIN_OFF   = 2'd0,
    PIN_CHAR  = 2'd1,
    PIN_BLOCK = 2'd2
  } pin_mode_e;

  // Pin mode from the two control bits; block mode needs the queues enabled.
  function automatic pin_mode_e mode_of(input logic fe, input logic bk);
    if (!fe) return PIN_OFF;
    if (bk)  return PIN_BLOCK;
    return PIN_CHAR;
  endfunction

  // Number of bytes a queue may hold in a given mode.
  function automatic int cap_of(input pin_mode_e m, input int depth);
    return (m == PIN_OFF) ? 1 : depth;
  endfunction

  // Trigger level clamped into 1..depth.
  function automatic int trig_clamp(input int t, input int depth);
    if (t < 1)     return 1;
    if (t > depth) return depth;
    return t;
  endfunction

endpackage

// File: rtl/rdy_byte_fifo.sv
module rdy_byte_fifo #(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] cnt,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = pop && (cnt != '0);
  assign push_ok = push && ((cnt < cap) || pop_ok);
  assign dout    = (cnt != '0) ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

endmodule

// File: rtl/rdy_pin_logic.sv
module rdy_pin_logic
  import fifo_rdy_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  pin_mode_e     mode,
  input  logic [LW-1:0] trig_eff,
  input  logic [LW-1:0] tx_cnt,
  input  logic [LW-1:0] rx_cnt,
  input  logic          rx_timeout,
  output logic          mode_chg,
  output logic          blk_latch,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  pin_mode_e mode_q;
  logic      rx_nonempty, lvl_hit, latch_d;

  assign mode_chg    = (mode != mode_q);
  assign rx_nonempty = (rx_cnt != '0);
  assign lvl_hit     = (rx_cnt >= trig_eff);
  // Hold the latch until empty; a mode change drops the held value.
  assign latch_d     = rx_nonempty &&
                       ((blk_latch && !mode_chg) || lvl_hit || rx_timeout);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PIN_OFF;
      blk_latch <= 1'b0;
      txrdy_n   <= 1'b0;
      rxrdy_n   <= 1'b1;
    end else begin
      mode_q    <= mode;
      blk_latch <= latch_d;
      if (mode == PIN_BLOCK) begin
        rxrdy_n <= !latch_d;
        txrdy_n <= (tx_cnt == LW'(DEPTH));
      end else begin
        rxrdy_n <= !rx_nonempty;
        txrdy_n <= (tx_cnt != '0);
      end
    end
  end

endmodule

// File: rtl/fifo_ready_gen.sv
module fifo_ready_gen
  import fifo_rdy_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          blk_mode,
  input  logic [LW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          tx_ovf,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  pin_mode_e     mode;
  logic [LW-1:0] cap, trig_eff;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          mode_chg, blk_latch;

  assign mode     = mode_of(fifo_en, blk_mode);
  assign cap      = LW'(cap_of(mode, DEPTH));
  assign trig_eff = LW'(trig_clamp(int'(rx_trig), DEPTH));

  rdy_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) tx_q (
    .clk(clk), .rst(rst), .cap(cap),
    .push(host_wr), .din(host_wdata),
    .pop(ser_tx_pop), .dout(ser_tx_data),
    .cnt(tx_level), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  rdy_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) rx_q (
    .clk(clk), .rst(rst), .cap(cap),
    .push(ser_rx_push), .din(ser_rx_data),
    .pop(host_rd), .dout(host_rdata),
    .cnt(rx_level), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  rdy_pin_logic #(.DEPTH(DEPTH)) pins (
    .clk(clk), .rst(rst), .mode(mode), .trig_eff(trig_eff),
    .tx_cnt(tx_level), .rx_cnt(rx_level), .rx_timeout(rx_timeout),
    .mode_chg(mode_chg), .blk_latch(blk_latch),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  always_ff @(posedge clk) begin
    if (rst)                         tx_ovf <= 1'b0;
    else if (host_wr && !tx_push_ok) tx_ovf <= 1'b1;
  end

endmodule

// File: rtl/fifo_ready_gen_chk.sv
module fifo_ready_gen_chk #(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          blk_mode,
  input logic          rx_timeout,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic [LW-1:0] trig_eff,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_ovf,
  input logic          txrdy_n,
  input logic          rxrdy_n,
  input logic          tx_push_ok,
  input logic          rx_push_ok,
  input logic          rx_pop_ok,
  input logic          mode_chg
);

  // R2
  lvl_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));

  // R9
  rx_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push_ok && rx_pop_ok |=> $stable(rx_level));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ovf |=> tx_ovf);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_ovf && !(host_wr && !tx_push_ok) |=> !tx_ovf);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd && (rx_level == '0) |-> (host_rdata == '0) && !rx_pop_ok);

  // R3
  char_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_en && blk_mode) |=>
      (rxrdy_n == ($past(rx_level) == '0)) && (txrdy_n == ($past(tx_level) != '0)));

  // R5
  blk_tx_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_en && blk_mode |=> txrdy_n == ($past(tx_level) == LW'(DEPTH)));

  // R4
  blk_rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_en && blk_mode && !mode_chg && !rxrdy_n && (rx_level != '0) |=> !rxrdy_n);

  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_en && blk_mode && mode_chg && (rx_level < trig_eff) && !rx_timeout |=> rxrdy_n);

endmodule

bind fifo_ready_gen fifo_ready_gen_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .blk_mode(blk_mode),
  .rx_timeout(rx_timeout), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .trig_eff(trig_eff), .tx_level(tx_level),
  .rx_level(rx_level), .tx_ovf(tx_ovf), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
  .tx_push_ok(tx_push_ok), .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok),
  .mode_chg(mode_chg)
);

// File: tb/fifo_ready_gen_tb_top.sv
`timescale 1ns/1ps
module fifo_ready_gen_tb_top;

  localparam int D  = 64;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst;
  logic          fifo_en, blk_mode, rx_timeout;
  logic [LW-1:0] rx_trig;
  logic          host_wr, host_rd, ser_tx_pop, ser_rx_push;
  logic [7:0]    host_wdata, ser_rx_data, host_rdata, ser_tx_data;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_ovf, txrdy_n, rxrdy_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fifo_ready_gen dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .blk_mode(blk_mode),
    .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  // Fields: fe bk trig rx_push rx_pop tx_push tx_pop exp_rxrdy_n exp_txrdy_n
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'd1,   7'd1,  7'd0, 7'd0,  7'd0, 1'b0, 1'b0}, // R3 off, one held
    {1'b0, 1'b0, 7'd1,   7'd3,  7'd0, 7'd2,  7'd0, 1'b0, 1'b1}, // R2 R7 one-byte cap
    {1'b1, 1'b0, 7'd1,   7'd5,  7'd5, 7'd3,  7'd2, 1'b1, 1'b1}, // R3 char
    {1'b1, 1'b0, 7'd1,   7'd5,  7'd4, 7'd3,  7'd3, 1'b0, 1'b0}, // R3 char
    {1'b1, 1'b1, 7'd8,   7'd7,  7'd0, 7'd63, 7'd0, 1'b1, 1'b0}, // R4 R5 below trig
    {1'b1, 1'b1, 7'd8,   7'd8,  7'd5, 7'd64, 7'd0, 1'b0, 1'b1}, // R4 R5 hysteresis, full
    {1'b1, 1'b1, 7'd8,   7'd8,  7'd8, 7'd64, 7'd1, 1'b1, 1'b0}, // R4 drained
    {1'b1, 1'b1, 7'd0,   7'd1,  7'd0, 7'd0,  7'd0, 1'b0, 1'b0}, // R6 zero acts as one
    {1'b1, 1'b1, 7'd64,  7'd64, 7'd0, 7'd0,  7'd0, 1'b0, 1'b0}, // R4 trig at depth
    {1'b1, 1'b1, 7'd64,  7'd63, 7'd0, 7'd0,  7'd0, 1'b1, 1'b0}, // R4 one short
    {1'b1, 1'b1, 7'd100, 7'd64, 7'd0, 7'd65, 7'd0, 1'b0, 1'b1}, // R6 R7 clamp, overflow
    {1'b0, 1'b1, 7'd8,   7'd1,  7'd0, 7'd1,  7'd0, 1'b0, 1'b1}  // R3 blk ignored when off
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fifo_en = 0; blk_mode = 0; rx_trig = 7'd1; rx_timeout = 0;
    host_wr = 0; host_rd = 0; ser_tx_pop = 0; ser_rx_push = 0;
    host_wdata = 8'h00; ser_rx_data = 8'h00;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic rx_push(input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      ser_rx_push = 1; ser_rx_data = base + 8'(k); step(); ser_rx_push = 0;
    end
  endtask

  task automatic rx_pop(input int n);
    for (int k = 0; k < n; k++) begin host_rd = 1; step(); host_rd = 0; end
  endtask

  task automatic tx_push(input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      host_wr = 1; host_wdata = base + 8'(k); step(); host_wr = 0;
    end
  endtask

  task automatic tx_pop(input int n);
    for (int k = 0; k < n; k++) begin ser_tx_pop = 1; step(); ser_tx_pop = 0; end
  endtask

  task automatic set_mode(input logic fe, input logic bk, input logic [LW-1:0] t);
    fifo_en = fe; blk_mode = bk; rx_trig = t; step();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    report();
  end

  initial begin
    // R1 reset defaults
    do_reset();
    chk("R1 rxrdy_n", rxrdy_n, 1);
    chk("R1 txrdy_n", txrdy_n, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 tx_ovf", tx_ovf, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      automatic logic [38:0] e = VEC[v];
      automatic int cap  = e[38] ? D : 1;
      automatic int rpu  = int'(e[29:23]);
      automatic int rpo  = int'(e[22:16]);
      automatic int tpu  = int'(e[15:9]);
      automatic int tpo  = int'(e[8:2]);
      automatic int rexp = ((rpu < cap) ? rpu : cap) - rpo;
      automatic int texp = ((tpu < cap) ? tpu : cap) - tpo;
      do_reset();
      set_mode(e[38], e[37], e[36:30]);
      rx_push(rpu, 8'h10);
      rx_pop(rpo);
      tx_push(tpu, 8'h40);
      tx_pop(tpo);
      step(2);
      chk($sformatf("R2 vec%0d rx_level", v), rx_level, rexp);
      chk($sformatf("R2 vec%0d tx_level", v), tx_level, texp);
      chk($sformatf("R7 vec%0d tx_ovf", v), tx_ovf, (tpu > cap) ? 1 : 0);
      chk($sformatf("R3/R4 vec%0d rxrdy_n", v), rxrdy_n, int'(e[1]));
      chk($sformatf("R3/R5 vec%0d txrdy_n", v), txrdy_n, int'(e[0]));
    end

    // R2 ordering on both queues
    do_reset();
    set_mode(1, 0, 7'd1);
    rx_push(4, 8'hA0);
    tx_push(3, 8'hB0);
    for (int k = 0; k < 4; k++) begin
      host_rd = 1; #1;
      chk("R2 rx order", host_rdata, 8'hA0 + k);
      step(); host_rd = 0;
    end
    for (int k = 0; k < 3; k++) begin
      ser_tx_pop = 1; #1;
      chk("R2 tx order", ser_tx_data, 8'hB0 + k);
      step(); ser_tx_pop = 0;
    end

    // R8 empty reads and pops
    host_rd = 1; #1;
    chk("R8 empty rdata", host_rdata, 0);
    step(); host_rd = 0;
    tx_pop(1);
    step();
    chk("R8 rx_level stays 0", rx_level, 0);
    chk("R8 tx_level stays 0", tx_level, 0);

    // R9 pin lags count by one clock
    do_reset();
    set_mode(1, 0, 7'd1);
    step();
    ser_rx_push = 1; step(); ser_rx_push = 0;
    chk("R9 count updated", rx_level, 1);
    chk("R9 pin not yet", rxrdy_n, 1);
    step();
    chk("R9 pin next clock", rxrdy_n, 0);

    // R9 simultaneous push and pop on receive queue
    rx_push(1, 8'h22);
    ser_rx_push = 1; host_rd = 1; step(); ser_rx_push = 0; host_rd = 0;
    chk("R9 same-cycle level", rx_level, 2);

    // R4 time-out behaviour
    do_reset();
    set_mode(1, 1, 7'd10);
    rx_timeout = 1; step(); rx_timeout = 0;
    step(2);
    chk("R4 timeout while empty", rxrdy_n, 1);
    rx_push(2, 8'h30);
    step(2);
    chk("R4 below trig", rxrdy_n, 1);
    rx_timeout = 1; step(); rx_timeout = 0;
    step(2);
    chk("R4 timeout low", rxrdy_n, 0);
    rx_pop(1); step(2);
    chk("R4 held low", rxrdy_n, 0);
    rx_pop(1); step(2);
    chk("R4 high on empty", rxrdy_n, 1);

    // R10 mode change clears latch
    do_reset();
    set_mode(1, 1, 7'd4);
    rx_push(4, 8'h50);
    step(2);
    chk("R10 latched", rxrdy_n, 0);
    rx_pop(2); step(2);
    chk("R10 still latched", rxrdy_n, 0);
    blk_mode = 0; step();
    blk_mode = 1; step(2);
    chk("R10 re-evaluated", rxrdy_n, 1);

    // R7 full transmit queue with same-cycle pop
    do_reset();
    set_mode(1, 1, 7'd1);
    tx_push(64, 8'h00);
    step(2);
    chk("R5 full pin", txrdy_n, 1);
    host_wr = 1; ser_tx_pop = 1; step(); host_wr = 0; ser_tx_pop = 0;
    chk("R7 write+pop level", tx_level, 64);
    chk("R7 write+pop no ovf", tx_ovf, 0);
    tx_push(1, 8'hFF);
    chk("R7 lone write ovf", tx_ovf, 1);
    chk("R7 lone write level", tx_level, 64);
    tx_pop(1); step();
    chk("R7 ovf sticky", tx_ovf, 1);

    report();
  end

endmodule